// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Plane

This block is the logic core of a small programmable logic cell. Twenty input signals enter the plane. Each signal is offered to the array both as itself and as its inverse, which gives forty literal columns. Sixty-four product-term rows form the AND of whichever literals their configuration includes. The rows are split into eight groups of eight, one group for each output. Each group ORs its rows into one sum bit.

Each row carries its own disable bit. The first row of each group can be taken out of its sum and exported on its own as an enable, under a per-group select. Every signal also has a "driven" flag. An undriven signal reads as logic 1, the way a pulled-up, unconnected pin would.

The plane holds no state and has no clock. Its configuration comes in as flat vectors from an external configuration store. Any change on an input or a configuration bit appears at the outputs in the same evaluation. Output macrocells, registers and the programming protocol live outside this block.

Top module: `pla_array`

## Requirements
- R1: Literal column 2*i carries signal i and column 2*i+1 carries its inverse. Row r uses connection bits r*40+c for c = 0..39. A bit value of 0 includes that literal in the AND and a value of 1 leaves it out. `term_out[r]` is the AND of the included literals.
- R2: A row that is not disabled and has all 40 connection bits at 1 drives its term to 1.
- R3: When `cfg_term_off[r]` is 1, `term_out[r]` is 0. That row then adds nothing to its group sum and gives 0 when used as an enable.
- R4: `sum_out[g]` is the OR of the rows 8*g to 8*g+7 that count towards the sum.
- R5: When `cfg_en_sel[g]` is 1, row 8*g is left out of `sum_out[g]` and `en_out[g]` equals that row's term. When `cfg_en_sel[g]` is 0, the row counts in the sum and `en_out[g]` is 0.
- R6: When `sig_drv[i]` is 0, signal i reads as logic 1 whatever `sig_in[i]` holds.
- R7: The outputs follow any change of input or configuration without a clock edge.
- R8: A row that includes both the true and the inverted literal of the same signal is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sig_in | input | 20 | Input signal values |
| sig_drv | input | 20 | Per-signal driven flag; 0 makes the signal read as 1 |
| cfg_conn | input | 2560 | Connection bits, 40 per row, row-major; 0 includes a literal |
| cfg_term_off | input | 64 | Per-row disable |
| cfg_en_sel | input | 8 | Per-group select that exports the first row as an enable |
| term_out | output | 64 | Raw product-term values |
| sum_out | output | 8 | Per-group OR sums |
| en_out | output | 8 | Per-group enable terms |

## Verification
The case hardest to reach from the ports is a product term that goes to 1 while several literals are included. With random connection bits a row almost always contains a contradiction or an unmet literal, so it stays at 0 and a wrong column mapping goes unseen. The stimulus therefore includes each literal with low probability. It also sweeps directed rows that include the true literals of four signals over all sixteen input values, and a single inverted literal while the driven flag of each signal is swept in turn.

// File: rtl/pla_pkg.sv
package pla_pkg;
    localparam int unsigned SIG_N      = 20;
    localparam int unsigned GRP_N      = 8;
    localparam int unsigned TERMS_PER  = 8;
    localparam int unsigned COL_N      = 2 * SIG_N;
    localparam int unsigned ROW_N      = GRP_N * TERMS_PER;
    localparam int unsigned CONN_W     = ROW_N * COL_N;
endpackage

// File: rtl/pla_literals.sv
module pla_literals #(
    parameter int unsigned SIGS = pla_pkg::SIG_N,
    localparam int unsigned COLS = 2 * SIGS
) (
    input  logic [SIGS-1:0] sig_in,
    input  logic [SIGS-1:0] sig_drv,
    output logic [COLS-1:0] lits
);
    // Undriven signals read as 1; each signal yields a true and an inverted column.
    for (genvar i = 0; i < SIGS; i++) begin : g_sig
        logic val;
        assign val           = sig_drv[i] ? sig_in[i] : 1'b1;
        assign lits[2*i]     = val;
        assign lits[2*i + 1] = ~val;
    end
endmodule

// File: rtl/pla_term.sv
module pla_term #(
    parameter int unsigned COLS = pla_pkg::COL_N
) (
    input  logic [COLS-1:0] lits,
    input  logic [COLS-1:0] mask,   // 1 = literal left out
    input  logic            off,
    output logic            term
);
    always_comb begin
        term = !off && (&(lits | mask));
    end

    always_comb begin
        assert_off_zero_R3: assert (!off || !term)
            else $error("disabled term is high");
        assert_empty_one_R2: assert (!(&mask) || off || term)
            else $error("empty row not high");
        for (int i = 0; i < COLS / 2; i++) begin
            if (!mask[2*i] && !mask[2*i+1]) begin
                assert_contra_zero_R8: assert (!term)
                    else $error("row with both polarities is high");
            end
        end
    end
endmodule

// File: rtl/pla_group.sv
module pla_group #(
    parameter int unsigned COLS  = pla_pkg::COL_N,
    parameter int unsigned TERMS = pla_pkg::TERMS_PER,
    localparam int unsigned CW   = TERMS * COLS
) (
    input  logic [COLS-1:0]  lits,
    input  logic [CW-1:0]    conn,
    input  logic [TERMS-1:0] off,
    input  logic             en_sel,
    output logic [TERMS-1:0] terms,
    output logic             sum,
    output logic             en
);
    for (genvar t = 0; t < TERMS; t++) begin : g_row
        pla_term #(.COLS(COLS)) u_term (
            .lits (lits),
            .mask (conn[t*COLS +: COLS]),
            .off  (off[t]),
            .term (terms[t])
        );
    end

    logic [TERMS-1:0] counted;
    always_comb begin
        counted    = terms;
        counted[0] = terms[0] & ~en_sel;
        sum        = |counted;
        en         = en_sel & terms[0];
    end

    always_comb begin
        assert_en_gate_R5: assert (!en || en_sel)
            else $error("enable active without select");
        assert_sum_cover_R4: assert (!(|terms[TERMS-1:1]) || sum)
            else $error("high term missing from sum");
    end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
    parameter int unsigned SIGS   = pla_pkg::SIG_N,
    parameter int unsigned GROUPS = pla_pkg::GRP_N,
    parameter int unsigned TERMS  = pla_pkg::TERMS_PER,
    localparam int unsigned COLS  = 2 * SIGS,
    localparam int unsigned ROWS  = GROUPS * TERMS,
    localparam int unsigned GCW   = TERMS * COLS
) (
    input  logic [SIGS-1:0]      sig_in,
    input  logic [SIGS-1:0]      sig_drv,
    input  logic [ROWS*COLS-1:0] cfg_conn,
    input  logic [ROWS-1:0]      cfg_term_off,
    input  logic [GROUPS-1:0]    cfg_en_sel,
    output logic [ROWS-1:0]      term_out,
    output logic [GROUPS-1:0]    sum_out,
    output logic [GROUPS-1:0]    en_out
);
    logic [COLS-1:0] lits;

    pla_literals #(.SIGS(SIGS)) u_lits (
        .sig_in  (sig_in),
        .sig_drv (sig_drv),
        .lits    (lits)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        pla_group #(.COLS(COLS), .TERMS(TERMS)) u_grp (
            .lits   (lits),
            .conn   (cfg_conn[g*GCW +: GCW]),
            .off    (cfg_term_off[g*TERMS +: TERMS]),
            .en_sel (cfg_en_sel[g]),
            .terms  (term_out[g*TERMS +: TERMS]),
            .sum    (sum_out[g]),
            .en     (en_out[g])
        );
    end

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            if (cfg_term_off[r]) begin
                assert_row_off_R3: assert (!term_out[r])
                    else $error("disabled row visible at output");
            end
        end
    end
endmodule

// File: tb/sim_pla_array.sv
module sim_pla_array;
    localparam int SIGS = 20, GROUPS = 8, TERMS = 8;
    localparam int COLS = 2 * SIGS, ROWS = GROUPS * TERMS;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [SIGS-1:0]      sig_in, sig_drv;
    logic [ROWS*COLS-1:0] conn;
    logic [ROWS-1:0]      toff;
    logic [GROUPS-1:0]    esel;
    logic [ROWS-1:0]      term_out;
    logic [GROUPS-1:0]    sum_out, en_out;

    int checks = 0, errors = 0;
    bit done = 0;

    pla_array u0 (
        .sig_in (sig_in), .sig_drv (sig_drv), .cfg_conn (conn),
        .cfg_term_off (toff), .cfg_en_sel (esel),
        .term_out (term_out), .sum_out (sum_out), .en_out (en_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic model_term(int r);
        if (toff[r]) return 1'b0;
        for (int c = 0; c < COLS; c++) begin
            logic s, lit;
            s   = sig_drv[c/2] ? sig_in[c/2] : 1'b1;
            lit = (c % 2 == 0) ? s : ~s;
            if (!conn[r*COLS + c] && !lit) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic compare_all(input string tag);
        logic [ROWS-1:0] et;
        logic [GROUPS-1:0] es, ee;
        for (int r = 0; r < ROWS; r++) et[r] = model_term(r);
        for (int g = 0; g < GROUPS; g++) begin
            es[g] = 1'b0;
            for (int t = 0; t < TERMS; t++)
                if (!(t == 0 && esel[g])) es[g] |= et[g*TERMS + t];
            ee[g] = esel[g] & et[g*TERMS];
        end
        chk({tag, " R1 terms"}, 64'(term_out), 64'(et));
        chk({tag, " R4 sums"}, 64'(sum_out), 64'(es));
        chk({tag, " R5 enables"}, 64'(en_out), 64'(ee));
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(7);
        sig_in = '0; sig_drv = '1; conn = '1; toff = '0; esel = '0;
        repeat (2) @(posedge clk);
        settle();
        // R2: empty rows all high
        chk("R2 empty rows", 64'(term_out), {64{1'b1}});
        chk("R4 sums of empty rows", 64'(sum_out), 64'hFF);
        chk("R5 no enables when unselected", 64'(en_out), 64'h0);

        // R8: every literal included -> contradiction
        @(posedge clk); conn = '0; sig_in = 20'hA5A5A;
        settle();
        chk("R8 contradiction", 64'(term_out), 64'h0);

        // R3: disabled empty rows
        @(posedge clk); conn = '1; toff = '1; esel = '1;
        settle();
        chk("R3 disabled terms", 64'(term_out), 64'h0);
        chk("R3 disabled sums", 64'(sum_out), 64'h0);
        chk("R3 disabled enables", 64'(en_out), 64'h0);

        // R5: only first row per group live
        for (int g = 0; g < GROUPS; g++) begin
            @(posedge clk); conn = '1; toff = '1; toff[g*TERMS] = 1'b0; esel = '0;
            settle();
            chk("R5 first row summed", 64'(sum_out[g]), 64'd1);
            chk("R5 enable idle", 64'(en_out[g]), 64'd0);
            @(posedge clk); esel[g] = 1'b1;
            settle();
            chk("R5 first row excluded", 64'(sum_out[g]), 64'd0);
            chk("R5 enable exported", 64'(en_out[g]), 64'd1);
        end

        // R1: exhaustive 4-input AND on row 9 (true literals 0..3)
        toff = '0; esel = '0;
        for (int v = 0; v < 16; v++) begin
            @(posedge clk);
            conn = '1;
            for (int k = 0; k < 4; k++) conn[9*COLS + 2*k] = 1'b0;
            conn[9*COLS + 2*5 + 1] = 1'b0; // R1: inverted literal of signal 5
            sig_in = '0; sig_in[3:0] = 4'(v);
            settle();
            chk("R1 4-input AND", 64'(term_out[9]), 64'(v == 15));
        end

        // R6: undriven signal reads as 1
        for (int k = 0; k < SIGS; k++) begin
            @(posedge clk);
            conn = '1; conn[2*k + 1] = 1'b0; // row 0, inverted literal of k
            sig_in = '0; sig_drv = '1; sig_drv[k] = 1'b0;
            settle();
            chk("R6 undriven inverted literal", 64'(term_out[0]), 64'd0);
            @(posedge clk); sig_drv[k] = 1'b1;
            settle();
            chk("R6 driven inverted literal", 64'(term_out[0]), 64'd1);
        end

        // R7: change without clock edge
        @(posedge clk); conn = '1; toff = '0; sig_drv = '1;
        #1 toff[20] = 1'b1;
        #1 chk("R7 immediate response", 64'(term_out[20]), 64'd0);

        // Random sparse configurations: R1, R4, R5, R3, R6
        for (int it = 0; it < 500; it++) begin
            @(posedge clk);
            for (int b = 0; b < ROWS*COLS; b++) conn[b] = ($urandom % 14) != 0;
            for (int r = 0; r < ROWS; r++) toff[r] = ($urandom % 6) == 0;
            esel    = 8'($urandom);
            sig_in  = 20'($urandom);
            sig_drv = 20'($urandom) | 20'($urandom);
            settle();
            compare_all("random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end
endmodule